// File: doc/BRIEF.md
# On-chip flash update sequencer

This block rewrites one configuration region of an on-chip flash. It has two memory-mapped master ports. One port writes the flash control register. The other port writes words into the flash data region. A single start pulse runs the whole update with no further help from outside:

1. Lift the write protection on every sector.
2. Command an erase of the configuration sector.
3. Wait a fixed erase time, measured by a local timer.
4. Take image words one at a time from a valid/ready stream and write each to the next flash word address.

The flash status register is never read. The erase ends on time alone, because the busy indication can fall back to idle before the erase has finished. Each data write ends when the data port's wait-request drops, because the write-success flag may never be set. A guard timer on each data write catches a flash that never releases wait-request. The timer lengths are parameters in milliseconds and microseconds. They are converted to clock cycles with the clock-frequency parameter, so a bench can scale them down.

Top module: `flash_update_seq`

## Requirements
- R1: After reset, `csrWrite`, `flashWrite`, `inReady`, `done` and `error` are all low, and the block stays idle until `start` is pulsed.
- R2: A start pulse in the idle state makes the block write 0xF07FFFFF (all sectors unprotected) to control address 1 (`csrAddr` = 1). The write is held until a cycle with `csrWait` low accepts it.
- R3: After the unprotect write is accepted, the block writes 0xF04FFFFF (erase the configuration sector, all sectors still unprotected) to control address 1. This write is also held until `csrWait` is low.
- R4: After the erase command is accepted, the block waits exactly ERASE_CYC cycles (CLK_FREQ_HZ/1000 × ERASE_MS). `inReady` rises on the cycle after that wait, counted from the accepting cycle as ERASE_CYC + 1 cycles. No data write happens earlier.
- R5: `inReady` is high only while the block waits for a word. A word taken with `inValid` is presented with `flashWrite` on the next cycle. `flashAddr` and `flashWdata` stay constant while `flashWait` is high, whatever the gaps in `inValid` are.
- R6: A data write completes in the first cycle where `flashWrite` is high and `flashWait` is low. Addresses start at 0 for each run and rise by one after each completed write.
- R7: Completing the write to `endAddr` raises `done` for exactly one cycle. After that, no further words are accepted or written. With `endAddr` = 0, exactly one word is written.
- R8: If `flashWait` stays high for PROG_CYC cycles of one data write (CLK_FREQ_HZ/1000 × PROG_US/1000), `flashWrite` drops. `error` then rises and stays high until the next start.
- R9: A start pulse during a run is ignored. No extra control write occurs and the erase wait is not restarted.
- R10: A start pulse after `done` or `error` begins a full new run: unprotect, erase, wait, and writes from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle pulse that begins an update |
| endAddr | input | ADDR_W | Last word address to program, held for the run |
| csrAddr | output | 1 | Control-port register select (1 = control register) |
| csrWrite | output | 1 | Control-port write request |
| csrWdata | output | 32 | Control-port write data |
| csrWait | input | 1 | Control-port wait-request |
| flashAddr | output | ADDR_W | Data-port word address |
| flashWrite | output | 1 | Data-port write request |
| flashWdata | output | DATA_W | Data-port write data |
| flashWait | input | 1 | Data-port wait-request |
| inData | input | DATA_W | Image word from the source |
| inValid | input | 1 | Source word valid |
| inReady | output | 1 | Sequencer ready for a word |
| done | output | 1 | One-cycle pulse when the last word is written |
| error | output | 1 | Level: a data write timed out |

## Verification
Two functions can fall on the same clock edge:

- A data write can complete in the very cycle that its guard timer reaches its limit. The bench sets both the stuck-write case and random wait lengths, and checks that a stuck write stays on the port for exactly PROG_CYC cycles before `error` appears. The ordinary writes must never reach the error state.
- A start pulse can land in the middle of the erase wait. That pulse is sent deliberately, and the bench checks that only two control writes are logged and that the wait still measures exactly ERASE_CYC + 1 cycles.

// File: rtl/fus_pkg.sv
package fus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLOCK,
    ST_ERASE_CMD,
    ST_ERASE_WAIT,
    ST_PROG_WAIT_DATA,
    ST_PROG_WRITE,
    ST_DONE,
    ST_ERROR
  } seqState_t;

  typedef struct packed {
    logic clrTimer;
    logic clrAddr;
    logic loadWord;
    logic incAddr;
    logic finish;
  } dpCmd_t;

  localparam logic [31:0] UNPROTECT_WORD = 32'hF07FFFFF;
  localparam logic [31:0] ERASE_WORD     = 32'hF04FFFFF;
  localparam logic        CTRL_REG_SEL   = 1'b1;

endpackage

// File: rtl/fus_dpath.sv
module fus_dpath
  import fus_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int ERASE_CYC = 400,
  parameter int PROG_CYC  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] inData,
  input  logic [ADDR_W-1:0] endAddr,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWdata,
  output logic              eraseElapsed,
  output logic              progElapsed,
  output logic              atEnd,
  output logic              donePulse
);

  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrTimer) timer <= '0;
    else                       timer <= timer + 1'b1;
  end

  assign eraseElapsed = (timer == CNT_W'(ERASE_CYC - 1));
  assign progElapsed  = (timer == CNT_W'(PROG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrAddr) flashAddr <= '0;
    else if (cmd.incAddr)     flashAddr <= flashAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             flashWdata <= '0;
    else if (cmd.loadWord) flashWdata <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) donePulse <= 1'b0;
    else       donePulse <= cmd.finish;
  end

  assign atEnd = (flashAddr == endAddr);

  // R6: the timer is cleared when a write begins, so it restarts per word
  a_r6_timer_restart: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrTimer |=> (timer == '0));

endmodule

// File: rtl/fus_ctrl.sv
module fus_ctrl
  import fus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        csrWait,
  input  logic        flashWait,
  input  logic        inValid,
  input  logic        eraseElapsed,
  input  logic        progElapsed,
  input  logic        atEnd,
  output dpCmd_t      cmd,
  output logic        csrAddr,
  output logic        csrWrite,
  output logic [31:0] csrWdata,
  output logic        flashWrite,
  output logic        inReady,
  output logic        error
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        nextState   = ST_UNLOCK;
        cmd.clrAddr = 1'b1;
      end
      ST_UNLOCK: if (!csrWait) nextState = ST_ERASE_CMD;
      ST_ERASE_CMD: if (!csrWait) begin
        nextState    = ST_ERASE_WAIT;
        cmd.clrTimer = 1'b1;
      end
      ST_ERASE_WAIT: if (eraseElapsed) nextState = ST_PROG_WAIT_DATA;
      ST_PROG_WAIT_DATA: if (inValid) begin
        nextState    = ST_PROG_WRITE;
        cmd.loadWord = 1'b1;
        cmd.clrTimer = 1'b1;
      end
      ST_PROG_WRITE: begin
        if (!flashWait) begin
          cmd.incAddr = 1'b1;
          if (atEnd) begin
            nextState  = ST_DONE;
            cmd.finish = 1'b1;
          end else begin
            nextState = ST_PROG_WAIT_DATA;
          end
        end else if (progElapsed) begin
          nextState = ST_ERROR;
        end
      end
      ST_DONE, ST_ERROR: if (start) begin
        nextState   = ST_UNLOCK;
        cmd.clrAddr = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign csrWrite   = (state == ST_UNLOCK) || (state == ST_ERASE_CMD);
  assign csrAddr    = CTRL_REG_SEL;
  assign csrWdata   = (state == ST_ERASE_CMD) ? ERASE_WORD : UNPROTECT_WORD;
  assign flashWrite = (state == ST_PROG_WRITE);
  assign inReady    = (state == ST_PROG_WAIT_DATA);
  assign error      = (state == ST_ERROR);

  // R4: the erase wait is left only when the datapath timer says so
  a_r4_erase_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE_WAIT && !eraseElapsed) |=> (state == ST_ERASE_WAIT));

  // R9: a start during the erase wait does not restart the sequence
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE_WAIT && start) |=> (state != ST_UNLOCK));

  // R3: the erase command follows only an accepted unprotect write
  a_r3_order: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_ERASE_CMD) |-> ($past(state) == ST_UNLOCK && !$past(csrWait)));

endmodule

// File: rtl/flash_update_seq.sv
module flash_update_seq
  import fus_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int ERASE_MS    = 400,
  parameter int PROG_US     = 1000,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] endAddr,
  output logic              csrAddr,
  output logic              csrWrite,
  output logic [31:0]       csrWdata,
  input  logic              csrWait,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashWrite,
  output logic [DATA_W-1:0] flashWdata,
  input  logic              flashWait,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              done,
  output logic              error
);

  localparam int KHZ       = CLK_FREQ_HZ / 1000;
  localparam int ERASE_RAW = KHZ * ERASE_MS;
  localparam int PROG_RAW  = KHZ * PROG_US / 1000;
  localparam int ERASE_CYC = (ERASE_RAW < 1) ? 1 : ERASE_RAW;
  localparam int PROG_CYC  = (PROG_RAW < 1) ? 1 : PROG_RAW;

  dpCmd_t cmd;
  logic   eraseElapsed, progElapsed, atEnd;

  fus_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .csrWait(csrWait),
    .flashWait(flashWait), .inValid(inValid), .eraseElapsed(eraseElapsed),
    .progElapsed(progElapsed), .atEnd(atEnd), .cmd(cmd), .csrAddr(csrAddr),
    .csrWrite(csrWrite), .csrWdata(csrWdata), .flashWrite(flashWrite),
    .inReady(inReady), .error(error)
  );

  fus_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) uDpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inData(inData), .endAddr(endAddr),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .eraseElapsed(eraseElapsed),
    .progElapsed(progElapsed), .atEnd(atEnd), .donePulse(done)
  );

  // R5: address and data hold while the flash stalls the write
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrite && flashWait && !error) |=> (error || (flashWrite &&
      $stable(flashAddr) && $stable(flashWdata))));

  // R7: done is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: error arises only from a stalled data write
  a_r8_error_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> $past(flashWrite && flashWait));

  // R2: the two master ports are never driven in the same cycle
  a_r2_ports_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(csrWrite && flashWrite));

  // R6: a completed write that is not the last advances the address by one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (flashWrite && !flashWait && !atEnd) |=> (flashAddr == $past(flashAddr) + 1'b1));

endmodule

// File: tb/tb_flash_update_seq.sv
`timescale 1ns/1ps
module tb_flash_update_seq;

  localparam int CLK_HZ = 100_000;
  localparam int E_MS   = 4;
  localparam int P_US   = 400;
  localparam int AW     = 8;
  localparam int DW     = 32;
  localparam int ECYC   = (CLK_HZ / 1000) * E_MS;         // 400
  localparam int PCYC   = (CLK_HZ / 1000) * P_US / 1000;  // 40

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [AW-1:0] endAddr = '0;
  logic csrAddr, csrWrite, flashWrite, inReady, done, error;
  logic [31:0] csrWdata;
  logic csrWait = 1'b0, flashWait = 1'b0, inValid = 1'b0;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] flashWdata, inData = '0;

  flash_update_seq #(.CLK_FREQ_HZ(CLK_HZ), .ERASE_MS(E_MS), .PROG_US(P_US),
                     .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .endAddr(endAddr),
    .csrAddr(csrAddr), .csrWrite(csrWrite), .csrWdata(csrWdata), .csrWait(csrWait),
    .flashAddr(flashAddr), .flashWrite(flashWrite), .flashWdata(flashWdata),
    .flashWait(flashWait), .inData(inData), .inValid(inValid), .inReady(inReady),
    .done(done), .error(error)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int sampleIdx = 0;
  bit finished = 1'b0;

  // model configuration
  int csrWaitN = 0, maxWait = 0, stuckAt = -1;
  bit gapMode = 1'b0;
  // monitor state
  int csrCount = 0, eraseSample = -1, gap = 0;
  bit gapSeen = 1'b0;
  logic [31:0] csrLog [4];
  logic csrSelLog [4];
  int nWrites = 0, addrBad = 0, dataBad = 0, earlyBad = 0, holdBad = 0;
  int doneCnt = 0, curCycles = 0, srcIdx = 0;
  bit srcAdvance = 1'b0, csrBusy = 1'b0, fBusy = 1'b0;
  int csrRem = 0, fRem = 0;
  logic [AW-1:0] hA;
  logic [DW-1:0] hD;

  function automatic logic [DW-1:0] pat(int i);
    return 32'h5A3C0000 + DW'(i * 7 + 1);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    sampleIdx++;
    // image source
    if (srcAdvance) begin srcIdx++; srcAdvance = 1'b0; end
    inValid = gapMode ? ($urandom_range(0, 2) != 0) : 1'b1;
    inData  = pat(srcIdx);
    if (inReady && inValid) srcAdvance = 1'b1;
    // erase-to-ready gap
    if (inReady && !gapSeen && eraseSample >= 0) begin
      gap = sampleIdx - eraseSample; gapSeen = 1'b1;
    end
    // control-port model
    if (csrWrite) begin
      if (!csrBusy) begin csrBusy = 1'b1; csrRem = csrWaitN; end
      else csrRem--;
      csrWait = (csrRem > 0);
      if (!csrWait) begin
        if (csrCount < 4) begin csrLog[csrCount] = csrWdata; csrSelLog[csrCount] = csrAddr; end
        csrCount++;
        if (csrWdata == 32'hF04FFFFF) eraseSample = sampleIdx;
        csrBusy = 1'b0;
      end
    end else begin
      csrWait = 1'b0; csrBusy = 1'b0;
    end
    // data-port model
    if (flashWrite) begin
      curCycles++;
      if (!fBusy) begin
        fBusy = 1'b1; fRem = $urandom_range(0, maxWait); hA = flashAddr; hD = flashWdata;
      end else begin
        fRem = (fRem > 0) ? fRem - 1 : 0;
        if (flashAddr != hA || flashWdata != hD) holdBad++;
      end
      flashWait = (stuckAt == nWrites) || (fRem > 0);
      if (!flashWait) begin
        if (flashAddr != AW'(nWrites)) addrBad++;
        if (flashWdata != pat(nWrites)) dataBad++;
        if (eraseSample < 0 || sampleIdx <= eraseSample + ECYC) earlyBad++;
        nWrites++; fBusy = 1'b0; curCycles = 0;
      end
    end else begin
      if (fBusy && !error) holdBad++;
      fBusy = 1'b0; flashWait = 1'b0;
    end
    if (done) doneCnt++;
    if (sampleIdx > 150000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", sampleIdx, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clearMon();
    @(posedge clk);
    csrCount = 0; eraseSample = -1; gap = 0; gapSeen = 1'b0;
    nWrites = 0; addrBad = 0; dataBad = 0; earlyBad = 0; holdBad = 0;
    doneCnt = 0; curCycles = 0; srcIdx = 0; srcAdvance = 1'b0;
  endtask

  task automatic runOnce(int endA, int cw, int mw, bit gp, int stk, bit poke);
    csrWaitN = cw; maxWait = mw; gapMode = gp; stuckAt = stk;
    endAddr = AW'(endA);
    clearMon();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (poke && eraseSample >= 0 && sampleIdx == eraseSample + 50) start = 1'b1;
      else start = 1'b0;
      if (doneCnt > 0 || error) break;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkCommon(int endA, string tag);
    chk(csrCount == 2, {tag, " R2 control writes"}, csrCount, 2);
    chk(csrLog[0] == 32'hF07FFFFF && csrSelLog[0] == 1'b1, {tag, " R2 unprotect word"}, csrLog[0], 32'hF07FFFFF);
    chk(csrLog[1] == 32'hF04FFFFF && csrSelLog[1] == 1'b1, {tag, " R3 erase word"}, csrLog[1], 32'hF04FFFFF);
    chk(gap == ECYC + 1, {tag, " R4 erase wait"}, gap, ECYC + 1);
    chk(earlyBad == 0, {tag, " R4 early write"}, earlyBad, 0);
    chk(holdBad == 0 && dataBad == 0, {tag, " R5 hold/data"}, holdBad + dataBad, 0);
    chk(addrBad == 0 && nWrites == endA + 1, {tag, " R6 addresses"}, nWrites, endA + 1);
    chk(doneCnt == 1, {tag, " R7 done width"}, doneCnt, 1);
    chk(!inReady && !flashWrite && !error, {tag, " R7 quiet after done"}, inReady, 0);
  endtask

  task automatic testReset();
    chk(!csrWrite && !flashWrite && !inReady && !done && !error, "R1 reset outputs",
        {csrWrite, flashWrite, inReady, done, error}, 0);
    repeat (5) @(negedge clk);
    chk(!csrWrite && !flashWrite, "R1 idle without start", csrWrite, 0);
  endtask

  task automatic testNormal();
    runOnce(5, 2, 3, 1'b0, -1, 1'b0);
    checkCommon(5, "normal");
  endtask

  task automatic testGaps();
    runOnce(3, 0, 0, 1'b1, -1, 1'b0);
    checkCommon(3, "gaps R5");
  endtask

  task automatic testSingle();
    runOnce(0, 1, 2, 1'b0, -1, 1'b0);
    checkCommon(0, "single R7");
  endtask

  task automatic testStartIgnored();
    runOnce(2, 0, 1, 1'b0, -1, 1'b1);
    chk(csrCount == 2, "R9 no extra control write", csrCount, 2);
    chk(gap == ECYC + 1, "R9 erase wait unchanged", gap, ECYC + 1);
    chk(nWrites == 3 && doneCnt == 1, "R9 run completes", nWrites, 3);
  endtask

  task automatic testStuck();
    runOnce(4, 0, 0, 1'b0, 2, 1'b0);
    chk(error, "R8 error raised", error, 1);
    chk(curCycles == PCYC, "R8 guard length", curCycles, PCYC);
    chk(nWrites == 2 && doneCnt == 0, "R8 writes before stall", nWrites, 2);
    repeat (20) @(negedge clk);
    chk(error && !flashWrite && !inReady, "R8 error held", error, 1);
  endtask

  task automatic testRestart();
    runOnce(2, 1, 2, 1'b0, -1, 1'b0);
    checkCommon(2, "restart R10");
    chk(!error, "R10 error cleared", error, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testGaps();
    testSingle();
    testStartIgnored();
    testStuck();
    testRestart();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule